// File: doc/BRIEF.md
# Compact Multi-Channel Hit Scaler

This block counts hit strobes on many channels without giving each channel a full-width counter. Each channel has only a narrow counter. A free-running phase counter freezes all narrow counters into per-channel holding registers in the same cycle and restarts them in that cycle. The sequencer then visits the channels one after another, one channel per slot. For each visited channel, one shared wide adder adds the held value to the channel's running total and writes the sum back into a paged total memory.

Accumulation writes into the page named by the page-select input. Any page and channel can be read through a registered read port. A clear request zeroes every total of the page that is selected when the request arrives. A walker visits the channels of that page one per cycle. Whenever an accumulation write needs the memory port, the walker waits.

Top module: `hit_scaler`

## Requirements
- R1: Each channel's narrow counter (CW = 8 bits) adds one for every clock cycle in which its hit strobe is high. Any number of channels may be high in the same cycle.
- R2: One cycle in every pass copies all narrow counters into their holding registers and restarts them. A hit in that same cycle is counted in the new interval and is not lost. The holding registers change only in that cycle.
- R3: The drain runs one channel per 2^SLOT_LG cycles, in ascending channel order. A full pass takes NCH*2^SLOT_LG = 128 cycles. Even with a hit in every cycle, a narrow counter never exceeds 128 within a pass, so it never overflows.
- R4: After the hits have been drained, a channel's total equals the number of hits it received while its page was selected.
- R5: Accumulation writes only into the page given by pg_sel (3 bits, 8 pages). Totals of the other pages are unchanged.
- R6: rd_total shows the stored total at (rd_pg, rd_ch) one clock after the address is applied. Address = rd_pg*NCH + rd_ch.
- R7: Totals wrap modulo 2^TW.
- R8: A one-cycle clr_req zeroes all NCH totals of the page selected in that cycle. The walk finishes within 2*NCH cycles and leaves other pages unchanged. A request made during a walk is ignored.
- R9: After reset, every total reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit | input | NCH | Per-channel single-cycle hit strobes |
| pg_sel | input | log2(NPAGE) | Page that accumulation and clear act on |
| clr_req | input | 1 | One-cycle request to clear the selected page |
| rd_pg | input | log2(NPAGE) | Read page |
| rd_ch | input | log2(NCH) | Read channel |
| rd_total | output | TW | Registered total at the read address |

## Verification
The bench holds a hit high for several whole passes. A design that dropped the hit in the snapshot cycle would come up short by one count per pass. A dense burst on the highest channel and simultaneous hits on all channels expose a drain that skips the last slot or mixes up channel indices. Page switching between bursts catches a design that writes into the wrong page or corrupts another page. A small-width instance is driven past 2^TW to confirm the total wraps instead of saturating. Clearing one page must leave the other pages intact.

// File: rtl/hit_scaler_pkg.sv
package hit_scaler_pkg;
  localparam int unsigned HS_NCH     = 64;
  localparam int unsigned HS_CW      = 8;
  localparam int unsigned HS_TW      = 32;
  localparam int unsigned HS_NPAGE   = 8;
  localparam int unsigned HS_SLOT_LG = 1;

  typedef enum logic {
    CLR_IDLE = 1'b0,
    CLR_WALK = 1'b1
  } clr_state_e;
endpackage

// File: rtl/hs_sequencer.sv
module hs_sequencer #(
  parameter int unsigned NCH     = 64,
  parameter int unsigned SLOT_LG = 1,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned PH_W   = CH_W + SLOT_LG
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            snap,
  output logic            drain_we,
  output logic [CH_W-1:0] drain_ch
);
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign snap     = (ph_q == '0);
  assign drain_ch = ph_q[PH_W-1:SLOT_LG];

  generate
    if (SLOT_LG == 0) begin : g_single
      assign drain_we = 1'b1;
    end else begin : g_multi
      assign drain_we = &ph_q[SLOT_LG-1:0];
      // R3: a drain write is followed by at least one idle cycle
      p_drain_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drain_we |=> !drain_we);
    end
  endgenerate
endmodule

// File: rtl/hs_chan_counter.sv
module hs_chan_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          snap,
  output logic [CW-1:0] held
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] hold_q, hold_d;

  always_comb begin
    cnt_d  = cnt_q + {{(CW-1){1'b0}}, hit};
    hold_d = hold_q;
    if (snap) begin
      cnt_d  = {{(CW-1){1'b0}}, hit};
      hold_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign held = hold_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && !snap && (cnt_q == {CW{1'b1}})));

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(hold_q));
endmodule

// File: rtl/hs_total_store.sv
module hs_total_store
  import hit_scaler_pkg::*;
#(
  parameter int unsigned NCH   = 64,
  parameter int unsigned NPAGE = 8,
  parameter int unsigned TW    = 32,
  parameter int unsigned CW    = 8,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned PG_W  = $clog2(NPAGE),
  localparam int unsigned AW    = CH_W + PG_W,
  localparam int unsigned DEPTH = NCH * NPAGE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_we,
  input  logic [CH_W-1:0] acc_ch,
  input  logic [PG_W-1:0] acc_pg,
  input  logic [CW-1:0]   acc_val,
  input  logic            clr_req,
  input  logic [PG_W-1:0] clr_pg,
  input  logic [PG_W-1:0] rd_pg,
  input  logic [CH_W-1:0] rd_ch,
  output logic [TW-1:0]   rd_total
);
  logic [TW-1:0] mem [DEPTH];
  logic [TW-1:0] rd_q;

  clr_state_e      cst_q, cst_d;
  logic [CH_W-1:0] cidx_q, cidx_d;
  logic [PG_W-1:0] cpg_q, cpg_d;

  logic            we;
  logic [AW-1:0]   waddr;
  logic [TW-1:0]   wdata;
  logic [AW-1:0]   acc_addr;

  assign acc_addr = {acc_pg, acc_ch};

  always_comb begin
    cst_d  = cst_q;
    cidx_d = cidx_q;
    cpg_d  = cpg_q;
    we     = 1'b0;
    waddr  = acc_addr;
    wdata  = mem[acc_addr] + {{(TW-CW){1'b0}}, acc_val};
    if (acc_we) begin
      we = 1'b1;
    end else if (cst_q == CLR_WALK) begin
      we     = 1'b1;
      waddr  = {cpg_q, cidx_q};
      wdata  = '0;
      cidx_d = cidx_q + 1'b1;
      if (cidx_q == CH_W'(NCH-1)) cst_d = CLR_IDLE;
    end
    if (cst_q == CLR_IDLE && clr_req) begin
      cst_d  = CLR_WALK;
      cidx_d = '0;
      cpg_d  = clr_pg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst_q  <= CLR_IDLE;
      cidx_q <= '0;
      cpg_q  <= '0;
      rd_q   <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      cst_q  <= cst_d;
      cidx_q <= cidx_d;
      cpg_q  <= cpg_d;
      rd_q   <= mem[{rd_pg, rd_ch}];
      if (we) mem[waddr] <= wdata;
    end
  end

  assign rd_total = rd_q;

  p_clr_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cst_q == CLR_WALK && !acc_we && cidx_q == CH_W'(NCH-1)) |=> (cst_q == CLR_IDLE));
endmodule

// File: rtl/hit_scaler.sv
module hit_scaler #(
  parameter int unsigned NCH     = hit_scaler_pkg::HS_NCH,
  parameter int unsigned CW      = hit_scaler_pkg::HS_CW,
  parameter int unsigned TW      = hit_scaler_pkg::HS_TW,
  parameter int unsigned NPAGE   = hit_scaler_pkg::HS_NPAGE,
  parameter int unsigned SLOT_LG = hit_scaler_pkg::HS_SLOT_LG,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned PG_W   = $clog2(NPAGE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  hit,
  input  logic [PG_W-1:0] pg_sel,
  input  logic            clr_req,
  input  logic [PG_W-1:0] rd_pg,
  input  logic [CH_W-1:0] rd_ch,
  output logic [TW-1:0]   rd_total
);
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic            snap;
  logic            drain_we;
  logic [CH_W-1:0] drain_ch;
  logic [CW-1:0]   held [NCH];

  hs_sequencer #(.NCH(NCH), .SLOT_LG(SLOT_LG)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .snap     (snap),
    .drain_we (drain_we),
    .drain_ch (drain_ch)
  );

  generate
    for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
      hs_chan_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_i_n),
        .hit   (hit[c]),
        .snap  (snap),
        .held  (held[c])
      );
    end
  endgenerate

  hs_total_store #(.NCH(NCH), .NPAGE(NPAGE), .TW(TW), .CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .acc_we   (drain_we),
    .acc_ch   (drain_ch),
    .acc_pg   (pg_sel),
    .acc_val  (held[drain_ch]),
    .clr_req  (clr_req),
    .clr_pg   (pg_sel),
    .rd_pg    (rd_pg),
    .rd_ch    (rd_ch),
    .rd_total (rd_total)
  );
endmodule

// File: tb/hit_scaler_test.sv
module hit_scaler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] hit = '0;
  logic [2:0]  pg_sel = '0;
  logic        clr_req = 1'b0;
  logic [2:0]  rd_pg = '0;
  logic [5:0]  rd_ch = '0;
  logic [31:0] rd_total;

  logic [63:0] hit_w = '0;
  logic [5:0]  rd_ch_w = '0;
  logic [11:0] rd_total_w;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hit_scaler uut (
    .clk(clk), .rst_n(rst_n), .hit(hit), .pg_sel(pg_sel), .clr_req(clr_req),
    .rd_pg(rd_pg), .rd_ch(rd_ch), .rd_total(rd_total)
  );

  hit_scaler #(.TW(12)) uut_w (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .pg_sel(3'd0), .clr_req(1'b0),
    .rd_pg(3'd0), .rd_ch(rd_ch_w), .rd_total(rd_total_w)
  );

  // page, channel, hit count, gap (0 = continuous), expected total
  localparam int VEC [6][5] = '{
    '{0, 0,   5, 1,   5},
    '{0, 63, 200, 0, 200},
    '{0, 0,   3, 7,   8},
    '{3, 0,  10, 2,  10},
    '{7, 31, 128, 0, 128},
    '{3, 63,  1, 0,   1}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic read_tot(input int pg, input int ch, output longint v);
    @(negedge clk);
    rd_pg = pg[2:0];
    rd_ch = ch[5:0];
    @(negedge clk);
    v = rd_total;
  endtask

  task automatic hits(input int ch, input int n, input int gap);
    if (gap == 0) begin
      @(negedge clk);
      hit[ch] = 1'b1;
      repeat (n) @(negedge clk);
      hit[ch] = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        hit[ch] = 1'b1;
        @(negedge clk);
        hit[ch] = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    read_tot(0, 5, v);  check("R9 reset pg0 ch5", v, 0);
    read_tot(7, 63, v); check("R9 reset pg7 ch63", v, 0);

    // R1 R3 R4 R5 R6: vector table
    for (int k = 0; k < 6; k++) begin
      pg_sel = VEC[k][0][2:0];
      hits(VEC[k][1], VEC[k][2], VEC[k][3]);
      repeat (300) @(negedge clk);
      read_tot(VEC[k][0], VEC[k][1], v);
      check($sformatf("R4 vector %0d", k), v, VEC[k][4]);
    end

    // R5: earlier pages untouched by later page writes
    read_tot(0, 0, v);  check("R5 pg0 ch0 kept", v, 8);
    read_tot(0, 63, v); check("R5 pg0 ch63 kept", v, 200);
    read_tot(3, 31, v); check("R5 pg3 ch31 untouched", v, 0);

    // R1: all channels together on page 1
    pg_sel = 3'd1;
    @(negedge clk);
    hit = '1;
    repeat (50) @(negedge clk);
    hit = '0;
    repeat (300) @(negedge clk);
    for (int c = 0; c < 64; c++) begin
      read_tot(1, c, v);
      check($sformatf("R1 all-channel ch%0d", c), v, 50);
    end

    // R2 R3: continuous hits across three passes, snapshot-cycle hits kept
    pg_sel = 3'd2;
    hits(10, 384, 0);
    repeat (300) @(negedge clk);
    read_tot(2, 10, v); check("R2 continuous 3 passes", v, 384);

    // R8: clear page 0, others stay
    pg_sel = 3'd0;
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    repeat (200) @(negedge clk);
    read_tot(0, 0, v);  check("R8 pg0 ch0 cleared", v, 0);
    read_tot(0, 63, v); check("R8 pg0 ch63 cleared", v, 0);
    read_tot(3, 0, v);  check("R8 pg3 ch0 kept", v, 10);
    read_tot(7, 31, v); check("R8 pg7 ch31 kept", v, 128);

    // R7: 12-bit instance wraps: 4224 mod 4096 = 128
    @(negedge clk);
    hit_w[2] = 1'b1;
    repeat (4224) @(negedge clk);
    hit_w[2] = 1'b0;
    repeat (300) @(negedge clk);
    rd_ch_w = 6'd2;
    @(negedge clk);
    check("R7 wrap", longint'(rd_total_w), 128);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule